// File: doc/BRIEF.md
# Quasi-Bidirectional Microcontroller Port Bank

This block is a bank of general-purpose I/O ports of the kind found beside a small 8-bit processor core. It has four 8-bit ports and one 4-bit port. Each line of each port has one latch bit. Software writes that bit over an internal bus, and the bit acts as both output value and input enable. There is no direction register: a line driven to 1 releases its pad so that it can be read as an input. Software has two read paths. One returns the latch contents. The other returns the pad level after it passes through a two-flop synchronizer.

Each line drives three registered pad controls: a strong pull-down, a weak pull-up and a strong pull-up. Ports 1 to 4 are quasi-bidirectional, so a line at 1 is held high only by its weak pull-up. Port 0 is open-drain, so a line at 1 floats. Port 0 can also be taken over by an external address/data bus controller, which is modelled here only as a set of inputs. While the bus controller owns port 0, the port 0 latch is forced to all ones. Port 0 then drives either the address or the data byte with the strong pull-up, or it floats while the bus is reading.

Writes can load a value or can combine it with the current latch contents. The combine always uses the latch, never the pad level. Because of this, a line that an outside device holds low does not clear a latch bit that software set to 1.

Top module: `mcu_port_bank`

## Requirements
- R1: After a synchronous reset, every latch bit is 1 and `rd_data` is 0. All strong pull-down and strong pull-up enables are 0. The weak pull-up enable is 1 on every line of ports 1 to 4 and 0 on port 0.
- R2: On ports 1 to 4, a latch bit of 0 gives pull-down 1 and weak pull-up 0, and a latch bit of 1 gives pull-down 0 and weak pull-up 1. Pad controls follow the latch one clock after the latch changes.
- R3: On port 0, the weak pull-up enable is always 0. Outside bus mode, a latch bit of 1 gives pull-down 0 and strong pull-up 0, so the line floats.
- R4: With `rd_pin`=0, `rd_data` returns the latch of the port chosen by `rd_sel` one clock later. With `rd_pin`=1, it returns the pad level, and a change on `pad_in` first shows on `rd_data` after the third rising edge.
- R5: When `wr_en` is high, the latch of port `wr_sel` is updated on the next edge according to `wr_op`. The encodings are: 00 load, 01 AND with the latch, 10 OR with the latch, 11 XOR with the latch. The current latch value is the operand, never the pad level. Without a write, the latch holds its value.
- R6: `wr_sel`/`rd_sel` values 0 to 4 choose ports 0 to 4. A write with a select of 5 or more changes no latch, and a read with a select of 5 or more returns 0.
- R7: Port 4 is 4 bits wide. It takes `wr_data[3:0]` and ignores the upper bits. When port 4 is read, `rd_data[7:4]` is 0.
- R8: While `bus_mode` is 1, the port 0 latch is forced to all ones and writes to port 0 are ignored. After bus mode ends, the latch still reads 0xFF.
- R9: While `bus_mode` and `bus_drive` are both 1, port 0 drives `bus_addr` when `bus_asel`=1 and `bus_data` when `bus_asel`=0. A 1 bit gives strong pull-up 1 and pull-down 0. A 0 bit gives pull-down 1 and strong pull-up 0. The pad controls change one clock after the bus inputs change.
- R10: While `bus_mode`=1 and `bus_drive`=0, every port 0 line has pull-down, weak pull-up and strong pull-up all at 0.
- R11: Ports 1 to 4 never enable the strong pull-up, and the bus inputs have no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Latch write strobe |
| wr_sel | input | 3 | Port chosen for the write |
| wr_op | input | 2 | Write operation: load, AND, OR or XOR |
| wr_data | input | 8 | Write operand |
| rd_sel | input | 3 | Port chosen for the read |
| rd_pin | input | 1 | 1 selects the synchronized pad level, 0 selects the latch |
| rd_data | output | 8 | Registered read result |
| pad_in | input | 36 | Pad levels; port p line i is at bit 8p+i, and port 4 is at bits 35:32 |
| bus_mode | input | 1 | External bus controller owns port 0 |
| bus_drive | input | 1 | Bus is in an output phase on port 0 |
| bus_asel | input | 1 | 1 drives the address byte, 0 drives the data byte |
| bus_addr | input | 8 | Low address byte from the bus controller |
| bus_data | input | 8 | Write data byte from the bus controller |
| pad_pd_en | output | 36 | Strong pull-down enables |
| pad_wpu_en | output | 36 | Weak pull-up enables |
| pad_spu_en | output | 36 | Strong pull-up enables |

## Verification
The hardest case to reach is a combine write to a line that an outside device holds low while its latch bit is 1. Here the pin path and the latch path disagree, and only a design that uses the latch as the operand keeps the bit at 1. The bench drives the pad of such a line low, issues an OR with zero, and then reads both paths to confirm that they differ. The bus takeover of port 0 is the other hard case. The bench writes to port 0 while the bus owns it and steps through the address, data and read phases. After release, it reads the latch back to confirm the forced ones and that the write was lost.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    OP_LOAD = 2'b00,
    OP_AND  = 2'b01,
    OP_OR   = 2'b10,
    OP_XOR  = 2'b11
  } latch_op_e;

  typedef enum logic {
    KIND_QUASI      = 1'b0,
    KIND_OPEN_DRAIN = 1'b1
  } port_kind_e;

endpackage

// File: rtl/gpio_port_latch.sv
module gpio_port_latch
  import gpio_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  latch_op_e    wr_op,
  input  logic [W-1:0] wr_data,
  input  logic         force_high,
  output logic [W-1:0] latch_q
);

  logic [W-1:0] next_val;

  always_comb begin
    unique case (wr_op)
      OP_LOAD: next_val = wr_data;
      OP_AND:  next_val = latch_q & wr_data;
      OP_OR:   next_val = latch_q | wr_data;
      OP_XOR:  next_val = latch_q ^ wr_data;
      default: next_val = wr_data;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)             latch_q <= '1;
    else if (force_high) latch_q <= '1;
    else if (wr_en)      latch_q <= next_val;
  end

  AST_FORCE_ONES: assert property (@(posedge clk) disable iff (rst)
    force_high |=> (latch_q == {W{1'b1}})); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !force_high) |=> $stable(latch_q)); // R5
  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !force_high && wr_op == OP_LOAD) |=> (latch_q == $past(wr_data))); // R5

endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pin_q
);

  localparam int LAST = STAGES - 1;

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    stage_q[0] <= pad_in;
    for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
  end

  assign pin_q = stage_q[LAST];

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_port_pkg::*;
#(
  parameter int         W    = 8,
  parameter port_kind_e KIND = KIND_QUASI
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] latch_q,
  input  logic         bus_mode,
  input  logic         bus_drive,
  input  logic         bus_asel,
  input  logic [W-1:0] bus_addr,
  input  logic [W-1:0] bus_data,
  output logic [W-1:0] pd_en,
  output logic [W-1:0] wpu_en,
  output logic [W-1:0] spu_en
);

  logic [W-1:0] pd_n, wpu_n, spu_n;
  logic [W-1:0] wpu_rst;

  generate
    if (KIND == KIND_OPEN_DRAIN) begin : g_od
      logic [W-1:0] bus_val;
      assign bus_val = bus_asel ? bus_addr : bus_data;
      assign wpu_rst = '0;
      always_comb begin
        wpu_n = '0;
        if (bus_mode) begin
          pd_n  = bus_drive ? ~bus_val : '0;
          spu_n = bus_drive ?  bus_val : '0;
        end else begin
          pd_n  = ~latch_q;
          spu_n = '0;
        end
      end
    end else begin : g_quasi
      logic unused_bus;
      assign unused_bus = ^{bus_mode, bus_drive, bus_asel, bus_addr, bus_data};
      assign wpu_rst = '1;
      always_comb begin
        pd_n  = ~latch_q;
        wpu_n = latch_q;
        spu_n = '0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pd_en  <= '0;
      wpu_en <= wpu_rst;
      spu_en <= '0;
    end else begin
      pd_en  <= pd_n;
      wpu_en <= wpu_n;
      spu_en <= spu_n;
    end
  end

  AST_PD_WPU_EXCL: assert property (@(posedge clk) disable iff (rst)
    ((pd_en & wpu_en) == '0)); // R2
  AST_PD_SPU_EXCL: assert property (@(posedge clk) disable iff (rst)
    ((pd_en & spu_en) == '0)); // R9

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int         W           = 8,
  parameter port_kind_e KIND        = KIND_QUASI,
  parameter int         SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  latch_op_e    wr_op,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] pad_in,
  input  logic         bus_mode,
  input  logic         bus_drive,
  input  logic         bus_asel,
  input  logic [W-1:0] bus_addr,
  input  logic [W-1:0] bus_data,
  output logic [W-1:0] latch_q,
  output logic [W-1:0] pin_q,
  output logic [W-1:0] pd_en,
  output logic [W-1:0] wpu_en,
  output logic [W-1:0] spu_en
);

  localparam bit HAS_BUS = (KIND == KIND_OPEN_DRAIN);

  logic force_high;
  assign force_high = HAS_BUS && bus_mode;

  gpio_port_latch #(.W(W)) u_latch (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_op(wr_op),
    .wr_data(wr_data), .force_high(force_high), .latch_q(latch_q)
  );

  gpio_pin_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .pad_in(pad_in), .pin_q(pin_q)
  );

  gpio_pad_ctrl #(.W(W), .KIND(KIND)) u_pad (
    .clk(clk), .rst(rst), .latch_q(latch_q),
    .bus_mode(bus_mode), .bus_drive(bus_drive), .bus_asel(bus_asel),
    .bus_addr(bus_addr), .bus_data(bus_data),
    .pd_en(pd_en), .wpu_en(wpu_en), .spu_en(spu_en)
  );

endmodule

// File: rtl/mcu_port_bank.sv
module mcu_port_bank
  import gpio_port_pkg::*;
#(
  parameter int WIDE_PORTS = 4,
  parameter int WIDE_W     = 8,
  parameter int NARROW_W   = 4,
  parameter int SEL_W      = 3
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                wr_en,
  input  logic [SEL_W-1:0]                    wr_sel,
  input  logic [1:0]                          wr_op,
  input  logic [WIDE_W-1:0]                   wr_data,
  input  logic [SEL_W-1:0]                    rd_sel,
  input  logic                                rd_pin,
  output logic [WIDE_W-1:0]                   rd_data,
  input  logic [WIDE_PORTS*WIDE_W+NARROW_W-1:0] pad_in,
  input  logic                                bus_mode,
  input  logic                                bus_drive,
  input  logic                                bus_asel,
  input  logic [WIDE_W-1:0]                   bus_addr,
  input  logic [WIDE_W-1:0]                   bus_data,
  output logic [WIDE_PORTS*WIDE_W+NARROW_W-1:0] pad_pd_en,
  output logic [WIDE_PORTS*WIDE_W+NARROW_W-1:0] pad_wpu_en,
  output logic [WIDE_PORTS*WIDE_W+NARROW_W-1:0] pad_spu_en
);

  localparam int NPORTS  = WIDE_PORTS + 1;
  localparam int NARROW0 = WIDE_PORTS * WIDE_W;
  localparam int PAD_EXT = WIDE_W - NARROW_W;

  latch_op_e         op;
  logic [WIDE_W-1:0] latch_arr [NPORTS];
  logic [WIDE_W-1:0] pin_arr   [NPORTS];
  logic [NPORTS-1:0] port_wr;

  assign op = latch_op_e'(wr_op);

  generate
    for (genvar p = 0; p < NPORTS; p++) begin : g_wr
      assign port_wr[p] = wr_en && (wr_sel == SEL_W'(p));
    end

    for (genvar p = 0; p < WIDE_PORTS; p++) begin : g_wide
      localparam port_kind_e K = (p == 0) ? KIND_OPEN_DRAIN : KIND_QUASI;
      gpio_port #(.W(WIDE_W), .KIND(K)) u_port (
        .clk(clk), .rst(rst), .wr_en(port_wr[p]), .wr_op(op),
        .wr_data(wr_data), .pad_in(pad_in[p*WIDE_W +: WIDE_W]),
        .bus_mode(bus_mode), .bus_drive(bus_drive), .bus_asel(bus_asel),
        .bus_addr(bus_addr), .bus_data(bus_data),
        .latch_q(latch_arr[p]), .pin_q(pin_arr[p]),
        .pd_en(pad_pd_en[p*WIDE_W +: WIDE_W]),
        .wpu_en(pad_wpu_en[p*WIDE_W +: WIDE_W]),
        .spu_en(pad_spu_en[p*WIDE_W +: WIDE_W])
      );
    end
  endgenerate

  logic [NARROW_W-1:0] n_latch, n_pin;

  gpio_port #(.W(NARROW_W), .KIND(KIND_QUASI)) u_narrow (
    .clk(clk), .rst(rst), .wr_en(port_wr[WIDE_PORTS]), .wr_op(op),
    .wr_data(wr_data[NARROW_W-1:0]), .pad_in(pad_in[NARROW0 +: NARROW_W]),
    .bus_mode(bus_mode), .bus_drive(bus_drive), .bus_asel(bus_asel),
    .bus_addr(bus_addr[NARROW_W-1:0]), .bus_data(bus_data[NARROW_W-1:0]),
    .latch_q(n_latch), .pin_q(n_pin),
    .pd_en(pad_pd_en[NARROW0 +: NARROW_W]),
    .wpu_en(pad_wpu_en[NARROW0 +: NARROW_W]),
    .spu_en(pad_spu_en[NARROW0 +: NARROW_W])
  );

  assign latch_arr[WIDE_PORTS] = {{PAD_EXT{1'b0}}, n_latch};
  assign pin_arr[WIDE_PORTS]   = {{PAD_EXT{1'b0}}, n_pin};

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_sel < SEL_W'(NPORTS)) begin
      rd_data <= rd_pin ? pin_arr[rd_sel] : latch_arr[rd_sel];
    end else begin
      rd_data <= '0;
    end
  end

  AST_RD_UNMAPPED: assert property (@(posedge clk) disable iff (rst)
    (rd_sel >= SEL_W'(NPORTS)) |=> (rd_data == '0)); // R6
  AST_QUASI_NO_SPU: assert property (@(posedge clk) disable iff (rst)
    (pad_spu_en[NARROW0+NARROW_W-1:WIDE_W] == '0)); // R11

endmodule

// File: tb/sim_mcu_port_bank.sv
module sim_mcu_port_bank;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [2:0]  wr_sel;
  logic [1:0]  wr_op;
  logic [7:0]  wr_data;
  logic [2:0]  rd_sel;
  logic        rd_pin;
  logic [7:0]  rd_data;
  logic [35:0] pad_in;
  logic        bus_mode, bus_drive, bus_asel;
  logic [7:0]  bus_addr, bus_data;
  logic [35:0] pd, wpu, spu;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  mcu_port_bank u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_op(wr_op),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_pin(rd_pin), .rd_data(rd_data),
    .pad_in(pad_in), .bus_mode(bus_mode), .bus_drive(bus_drive),
    .bus_asel(bus_asel), .bus_addr(bus_addr), .bus_data(bus_data),
    .pad_pd_en(pd), .pad_wpu_en(wpu), .pad_spu_en(spu)
  );

  // {sel, op, data, expected latch readback}
  localparam logic [20:0] VEC [12] = '{
    {3'd1, 2'b00, 8'h5A, 8'h5A},
    {3'd1, 2'b01, 8'h0F, 8'h0A},
    {3'd1, 2'b10, 8'hC0, 8'hCA},
    {3'd1, 2'b11, 8'hFF, 8'h35},
    {3'd2, 2'b00, 8'h00, 8'h00},
    {3'd2, 2'b11, 8'h81, 8'h81},
    {3'd4, 2'b00, 8'hF3, 8'h03},
    {3'd4, 2'b10, 8'h08, 8'h0B},
    {3'd0, 2'b00, 8'h3C, 8'h3C},
    {3'd5, 2'b00, 8'h00, 8'h00},
    {3'd3, 2'b01, 8'hA5, 8'hA5},
    {3'd1, 2'b00, 8'hFF, 8'hFF}
  };

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] field(input logic [35:0] v, input int p);
    if (p < 4) return v[p*8 +: 8];
    return {4'b0, v[35:32]};
  endfunction

  task automatic do_write(input logic [2:0] s, input logic [1:0] o, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_op = o; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_latch(input logic [2:0] s);
    rd_sel = s; rd_pin = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R0 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; wr_en = 0; wr_sel = 0; wr_op = 0; wr_data = 0;
    rd_sel = 0; rd_pin = 0; pad_in = '1;
    bus_mode = 0; bus_drive = 0; bus_asel = 0; bus_addr = 0; bus_data = 0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 rd_data", {28'b0, rd_data}, 36'h0);
    chk("R1 pd", pd, 36'h0);
    chk("R1 wpu", wpu, 36'hFFFFFFF00);
    chk("R1 spu", spu, 36'h0);
    rst = 1'b0;
    read_latch(3'd3);
    chk("R1 latch port3", {28'b0, rd_data}, 36'hFF);
    read_latch(3'd4);
    chk("R1 R7 latch port4", {28'b0, rd_data}, 36'h0F);

    // R2 R3 R5 R6 R7 vector walk
    for (int i = 0; i < 12; i++) begin
      logic [2:0] s; logic [1:0] o; logic [7:0] d, e;
      {s, o, d, e} = VEC[i];
      do_write(s, o, d);
      rd_sel = s; rd_pin = 1'b0;
      @(negedge clk);
      chk("R5 R6 R7 latch readback", {28'b0, rd_data}, {28'b0, e});
      if (s == 3'd0) begin
        chk("R3 od pd", {28'b0, field(pd, 0)}, {28'b0, ~e});
        chk("R3 od wpu", {28'b0, field(wpu, 0)}, 36'h0);
      end else if (s < 3'd5) begin
        logic [7:0] m;
        m = (s == 3'd4) ? 8'h0F : 8'hFF;
        chk("R2 quasi pd", {28'b0, field(pd, int'(s))}, {28'b0, ~e & m});
        chk("R2 quasi wpu", {28'b0, field(wpu, int'(s))}, {28'b0, e});
      end
    end

    // R4 pin read latency
    @(negedge clk);
    pad_in[23:16] = 8'h5A; rd_sel = 3'd2; rd_pin = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R4 pin not yet", {28'b0, rd_data}, 36'hFF);
    @(negedge clk);
    chk("R4 pin after sync", {28'b0, rd_data}, 36'h5A);

    // R5 combine uses latch, not pin held low
    pad_in[15:8] = 8'h00;
    do_write(3'd1, 2'b10, 8'h00);
    read_latch(3'd1);
    chk("R5 latch kept", {28'b0, rd_data}, 36'hFF);
    rd_pin = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 pin low", {28'b0, rd_data}, 36'h00);

    // R6 unmapped write changes nothing
    do_write(3'd6, 2'b11, 8'hFF);
    read_latch(3'd1);
    chk("R6 port1 unchanged", {28'b0, rd_data}, 36'hFF);
    read_latch(3'd3);
    chk("R6 port3 unchanged", {28'b0, rd_data}, 36'hA5);

    // R8 R9 R10 R11 bus takeover of port0
    bus_mode = 1; bus_drive = 1; bus_asel = 1; bus_addr = 8'hA5; bus_data = 8'h3C;
    @(negedge clk);
    chk("R9 addr pd", {28'b0, field(pd, 0)}, 36'h5A);
    chk("R9 addr spu", {28'b0, field(spu, 0)}, 36'hA5);
    chk("R3 bus wpu", {28'b0, field(wpu, 0)}, 36'h0);
    bus_asel = 0;
    @(negedge clk);
    chk("R9 data pd", {28'b0, field(pd, 0)}, 36'hC3);
    chk("R9 data spu", {28'b0, field(spu, 0)}, 36'h3C);
    chk("R11 no spu elsewhere", {8'b0, spu[35:8]}, 36'h0);
    chk("R11 port1 wpu", {28'b0, field(wpu, 1)}, 36'hFF);
    chk("R11 port2 pd", {28'b0, field(pd, 2)}, 36'h7E);
    bus_drive = 0;
    @(negedge clk);
    chk("R10 pd float", {28'b0, field(pd, 0)}, 36'h0);
    chk("R10 spu float", {28'b0, field(spu, 0)}, 36'h0);
    do_write(3'd0, 2'b00, 8'h00);
    read_latch(3'd0);
    chk("R8 forced latch", {28'b0, rd_data}, 36'hFF);
    bus_mode = 0;
    @(negedge clk);
    chk("R8 after exit pd", {28'b0, field(pd, 0)}, 36'h0);
    read_latch(3'd0);
    chk("R8 after exit latch", {28'b0, rd_data}, 36'hFF);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule